// File: doc/BRIEF.md
# MDIO Management Frame Master

This block drives the two-wire station management interface of an Ethernet PHY in its clause 22 form. Software programs a clock divider and an output hold time in a timing register. It then writes one 32-bit command word into the data register. Each such write launches one complete management frame on MDC/MDIO: 32 preamble ones followed by the 32 command bits.

For a read frame, the block stops driving MDIO from the turnaround onward and shifts in the 16 bits the PHY returns. It places them in the low half of the same data register. Whichever the opcode, the end of a frame sets a sticky completion flag. Software clears that flag by writing a one to it.

The register port is a single-cycle write strobe with an address. Reads are combinational. MDIO is split into an output, an output enable and an input, so the pad tristate stays outside the block.

Top module: `mdio_master`

## Requirements
- R1: After a synchronous active-low reset, mdc and mdio_oe are 0. The data, timing and event registers (addresses 0, 1 and 2 on reg_addr) all read as zero.
- R2: With the latched divider value S, where S is the timing field (bits 6:1 of address 1) and a field value below 2 counts as 2, each frame bit lasts 2*S clocks. MDC is low for the first S of them and high for the last S.
- R3: A frame is 64 bits. It is 32 ones followed by data register bits 31 down to 0, MSB first. The value on mdio_o in the first cycle in which mdc is high equals the bit of that period.
- R4: mdio_o changes only in the low phase. It keeps the previous bit for H+1 clocks after the MDC falling edge, where H = min(hold field bits 10:8 of address 1, S-2).
- R5: When command bits 29:28 equal 2'b10 (read), mdio_oe falls H+1 clocks into frame bit 46 (the first turnaround bit) and stays low to the end. mdio_i is sampled in the first high cycle of MDC in bits 48..63. After the frame, data register bits 15:0 hold those 16 bits MSB first, and bits 31:16 keep the command.
- R6: For any other opcode, mdio_oe stays high for the whole frame and the data register keeps the command word.
- R7: Event register bit 0 is set in the clock after a frame ends. Writing 1 to it clears it. Writing 0 leaves it set.
- R8: Event register bit 1 (busy) is high from the clock after the command write until the frame ends. A data register write while busy is ignored: the frame in flight is unchanged and the register is not overwritten.
- R9: The timing register keeps only bits 6:1 and 10:8, and its other bits read as zero. A write during a frame affects only the next frame.
- R10: Between frames, mdc is low and mdio_oe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 data, 1 timing, 2 event |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
A frame begins in the cycle after the edge that accepts the command write. Frame bit b, cycle c within the bit, then occupies bench cycle t = 2*S*b + c. The expected mdc, mdio_o and mdio_oe for every such t are computed from S, H and the command, and compared one cycle at a time on the falling clock edge.

The completion flag, the cleared busy bit and the read-back data are due in the first cycle after t = 128*S-1. They are read there, together with the idle state of the pins. The bench drives the PHY's reply bits at the start of each data bit's low phase, so each bit is stable well before the sampling cycle.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
// Package: shared frame constants and register select codes for the
// management master. Assumes clause 22 framing (32-bit command word).
package mdio_pkg;
    localparam int CMD_W     = 32;
    localparam int CMD_IW    = $clog2(CMD_W);
    localparam int DATA_W    = 16;
    localparam int PRE_LEN   = 32;
    localparam int FRAME_LEN = PRE_LEN + CMD_W;
    localparam int BIT_W     = $clog2(FRAME_LEN);
    localparam int TA_IDX    = PRE_LEN + 14;  // first turnaround bit
    localparam int RXD_IDX   = PRE_LEN + 16;  // first data bit
    localparam int OP_HI     = 29;
    localparam int OP_LO     = 28;
    localparam int SPD_LSB   = 1;
    localparam int HOLD_LSB  = 8;
    localparam int EVT_DONE  = 0;
    localparam int EVT_BUSY  = 1;
    localparam logic [1:0] OP_READ = 2'b10;

    typedef enum logic [1:0] {
        SEL_DATA  = 2'd0,
        SEL_SPEED = 2'd1,
        SEL_EVENT = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/mdio_regs.sv
`timescale 1ns/1ps
// Module: register file of the management master. It holds the
// command/data word, the timing fields, the sticky completion flag and the
// busy flag. It issues a one-cycle start when a command is accepted.
// Assumes frame_done is a one-cycle pulse on the last clock of a frame.
module mdio_regs
    import mdio_pkg::*;
#(
    parameter int SPEED_W = 6,
    parameter int HOLD_W  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [1:0]         reg_addr,
    input  logic [CMD_W-1:0]   reg_wdata,
    output logic [CMD_W-1:0]   reg_rdata,
    input  logic               frame_done,
    input  logic [DATA_W-1:0]  rx_data,
    output logic               start,
    output logic               busy,
    output logic               is_read,
    output logic [CMD_W-1:0]   cmd,
    output logic [SPEED_W-1:0] speed,
    output logic [HOLD_W-1:0]  hold
);
    logic [CMD_W-1:0]   data_q;
    logic [SPEED_W-1:0] speed_q;
    logic [HOLD_W-1:0]  hold_q;
    logic               done_q;
    logic               busy_q;
    logic               wr_data, wr_speed, wr_event;
    logic [CMD_W-1:0]   speed_word;

    // Decode the write strobe per register.
    always_comb begin
        wr_data  = reg_we && (reg_addr == SEL_DATA);
        wr_speed = reg_we && (reg_addr == SEL_SPEED);
        wr_event = reg_we && (reg_addr == SEL_EVENT);
    end

    assign start   = wr_data && !busy_q;
    assign busy    = busy_q;
    assign cmd     = data_q;
    assign speed   = speed_q;
    assign hold    = hold_q;
    assign is_read = (data_q[OP_HI:OP_LO] == OP_READ);

    // Command word: loaded on an accepted write, read data merged at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (start) begin
            data_q <= reg_wdata;
        end else if (frame_done && is_read) begin
            data_q <= {data_q[CMD_W-1:DATA_W], rx_data};
        end
    end

    // Timing fields: only the divider and hold bits are stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            speed_q <= '0;
            hold_q  <= '0;
        end else if (wr_speed) begin
            speed_q <= reg_wdata[SPD_LSB +: SPEED_W];
            hold_q  <= reg_wdata[HOLD_LSB +: HOLD_W];
        end
    end

    // Completion flag: set by the frame end, cleared by a write of one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else if (frame_done) begin
            done_q <= 1'b1;
        end else if (wr_event && reg_wdata[EVT_DONE]) begin
            done_q <= 1'b0;
        end
    end

    // Busy flag: spans from accepted command to frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
        end else if (start) begin
            busy_q <= 1'b1;
        end else if (frame_done) begin
            busy_q <= 1'b0;
        end
    end

    // Place the timing fields at their bit positions for read-back.
    always_comb begin
        speed_word = '0;
        speed_word[SPD_LSB +: SPEED_W] = speed_q;
        speed_word[HOLD_LSB +: HOLD_W] = hold_q;
    end

    // Combinational read mux.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            SEL_DATA:  reg_rdata = data_q;
            SEL_SPEED: reg_rdata = speed_word;
            SEL_EVENT: begin
                reg_rdata[EVT_DONE] = done_q;
                reg_rdata[EVT_BUSY] = busy_q;
            end
            default:   reg_rdata = '0;
        endcase
    end

    // A command written mid-frame must not disturb the stored word.
    assert_cmd_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && wr_data && !frame_done) |=> $stable(data_q));

    // Writing zero to the flag keeps it set.
    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && !(wr_event && reg_wdata[EVT_DONE])) |=> done_q);

    // The frame end raises the flag and drops busy together.
    assert_flag_on_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> (done_q && !busy_q));
endmodule

// File: rtl/mdio_clkgen.sv
`timescale 1ns/1ps
// Module: MDC generator. It latches the divider and hold values at frame
// start and runs a per-bit phase counter. MDC is low for the first S
// clocks of a bit and high for the next S. It emits strobes for the MDIO
// update (H clocks after the fall), the sample (first high clock) and the
// end of the bit. Assumes S >= 2 after clamping, with H clamped to S-2.
module mdio_clkgen #(
    parameter int SPEED_W = 6,
    parameter int HOLD_W  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               run,
    input  logic [SPEED_W-1:0] speed,
    input  logic [HOLD_W-1:0]  hold,
    output logic               mdc,
    output logic               drive_stb,
    output logic               sample_stb,
    output logic               bit_end
);
    localparam int CW = SPEED_W + 1;

    logic [CW-1:0] se_q, hc_q, cnt_q;
    logic [CW-1:0] se_new, hc_lim, hc_new, top;

    // Clamp the programmed values into a usable phase plan.
    always_comb begin
        se_new = (speed < SPEED_W'(2)) ? CW'(2) : CW'(speed);
        hc_lim = se_new - CW'(2);
        hc_new = (CW'(hold) > hc_lim) ? hc_lim : CW'(hold);
    end

    assign top = (se_q << 1) - CW'(1);

    // Phase counter and MDC level, with timing latched per frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            se_q  <= CW'(2);
            hc_q  <= '0;
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else if (start) begin
            se_q  <= se_new;
            hc_q  <= hc_new;
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else if (run) begin
            if (cnt_q == top) begin
                cnt_q <= '0;
                mdc   <= 1'b0;
            end else begin
                cnt_q <= cnt_q + CW'(1);
                if (cnt_q == se_q - CW'(1)) begin
                    mdc <= 1'b1;
                end
            end
        end
    end

    // Strobes derived from the phase counter.
    always_comb begin
        drive_stb  = run && (cnt_q == hc_q);
        sample_stb = run && (cnt_q == se_q);
        bit_end    = run && (cnt_q == top);
    end

    // The MDIO update must land before the rising edge.
    assert_update_before_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (hc_q < se_q - CW'(1)));
endmodule

// File: rtl/mdio_shifter.sv
`timescale 1ns/1ps
// Module: frame shifter. It counts the 64 frame bits, selects the outgoing
// bit (preamble one or command bit), releases MDIO from the turnaround of
// a read, and shifts in the 16 reply bits. Assumes the strobes come from
// mdio_clkgen and that cmd is stable for the whole frame.
module mdio_shifter
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              run,
    input  logic              is_read,
    input  logic [CMD_W-1:0]  cmd,
    input  logic              drive_stb,
    input  logic              sample_stb,
    input  logic              bit_end,
    input  logic              mdio_i,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic [DATA_W-1:0] rx_data,
    output logic              frame_done
);
    logic [BIT_W-1:0] bit_q;
    logic             tx_bit;

    // Choose the bit for the current position, MSB of the command first.
    always_comb begin
        if (bit_q < BIT_W'(PRE_LEN)) begin
            tx_bit = 1'b1;
        end else begin
            tx_bit = cmd[CMD_IW'(CMD_W-1) - bit_q[CMD_IW-1:0]];
        end
    end

    assign frame_done = bit_end && (bit_q == BIT_W'(FRAME_LEN-1));

    // Bit position counter across the frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_q <= '0;
        end else if (start) begin
            bit_q <= '0;
        end else if (bit_end && !frame_done) begin
            bit_q <= bit_q + BIT_W'(1);
        end
    end

    // MDIO output value and enable, updated at the hold point.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mdio_o  <= 1'b0;
            mdio_oe <= 1'b0;
        end else if (start) begin
            mdio_o  <= 1'b1;
            mdio_oe <= 1'b1;
        end else if (frame_done) begin
            mdio_oe <= 1'b0;
        end else if (drive_stb) begin
            mdio_o <= tx_bit;
            if (is_read && (bit_q >= BIT_W'(TA_IDX))) begin
                mdio_oe <= 1'b0;
            end
        end
    end

    // Capture the PHY reply on the first high clock of each data bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data <= '0;
        end else if (start) begin
            rx_data <= '0;
        end else if (sample_stb && (bit_q >= BIT_W'(RXD_IDX))) begin
            rx_data <= {rx_data[DATA_W-2:0], mdio_i};
        end
    end

    // A write frame drives MDIO from start to end.
    assert_drive_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !is_read) |-> mdio_oe);

    // A read frame has released MDIO after the first turnaround bit.
    assert_release_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && is_read && (bit_q > BIT_W'(TA_IDX))) |-> !mdio_oe);
endmodule

// File: rtl/mdio_master.sv
`timescale 1ns/1ps
// Module: clause 22 management master top. A register write launches one
// frame on MDC/MDIO. Read replies land in the data register and a sticky
// flag marks completion. Assumes the pad tristate is built outside from
// mdio_o and mdio_oe.
module mdio_master
    import mdio_pkg::*;
#(
    parameter int SPEED_W = 6,
    parameter int HOLD_W  = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic               start, busy, is_read, frame_done;
    logic               drive_stb, sample_stb, bit_end;
    logic [CMD_W-1:0]   cmd;
    logic [DATA_W-1:0]  rx_data;
    logic [SPEED_W-1:0] speed;
    logic [HOLD_W-1:0]  hold;

    mdio_regs #(.SPEED_W(SPEED_W), .HOLD_W(HOLD_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .frame_done (frame_done),
        .rx_data    (rx_data),
        .start      (start),
        .busy       (busy),
        .is_read    (is_read),
        .cmd        (cmd),
        .speed      (speed),
        .hold       (hold)
    );

    mdio_clkgen #(.SPEED_W(SPEED_W), .HOLD_W(HOLD_W)) u_clkgen (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .run        (busy),
        .speed      (speed),
        .hold       (hold),
        .mdc        (mdc),
        .drive_stb  (drive_stb),
        .sample_stb (sample_stb),
        .bit_end    (bit_end)
    );

    mdio_shifter u_shifter (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .run        (busy),
        .is_read    (is_read),
        .cmd        (cmd),
        .drive_stb  (drive_stb),
        .sample_stb (sample_stb),
        .bit_end    (bit_end),
        .mdio_i     (mdio_i),
        .mdio_o     (mdio_o),
        .mdio_oe    (mdio_oe),
        .rx_data    (rx_data),
        .frame_done (frame_done)
    );

    // Outside a frame the bus is quiet.
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe));

    // MDIO never moves while MDC is high.
    assert_steady_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mdc && $past(mdc)) |-> $stable(mdio_o));
endmodule

// File: tb/tb_mdio_master.sv
`timescale 1ns/1ps
module tb_mdio_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;
    int          checks = 0;
    int          errors = 0;

    always #2 clk = ~clk;

    mdio_master dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    function automatic logic fval(input logic [31:0] c, input int b);
        if (b < 32) return 1'b1;
        return c[63-b];
    endfunction

    function automatic logic [31:0] spd_word(input logic [5:0] s, input logic [2:0] h);
        return {21'd0, h, 1'b0, s, 1'b0};
    endfunction

    // One frame, checked cycle by cycle against the computed timeline.
    task automatic run_frame(input logic [5:0] spd, input logic [2:0] hld, input bit set_spd,
                             input bit is_rd, input logic [4:0] pa, input logic [4:0] ra,
                             input logic [15:0] wd, input logic [15:0] phy,
                             input bit poke, input logic [5:0] p_spd, input logic [2:0] p_hld);
        int se, hc, n, b, c;
        bit bad [4];
        logic [31:0] fa [4];
        logic [31:0] fe [4];
        logic [31:0] cmd, r;
        logic em, eo, ev;
        for (int k = 0; k < 4; k++) begin bad[k] = 0; fa[k] = 0; fe[k] = 0; end
        if (set_spd) wr(2'd1, spd_word(spd, hld));
        se = (spd < 2) ? 2 : int'(spd);
        hc = (int'(hld) > se - 2) ? se - 2 : int'(hld);
        cmd = {2'b01, is_rd ? 2'b10 : 2'b01, pa, ra, 2'b10, is_rd ? 16'h0000 : wd};
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = cmd;
        @(negedge clk);
        reg_we = 1'b0;
        n = 128 * se;
        for (int t = 0; t < n; t++) begin
            b = t / (2 * se);
            c = t % (2 * se);
            em = (c >= se);
            eo = !(is_rd && (b > 46 || (b == 46 && c > hc)));
            ev = (c > hc) ? fval(cmd, b) : fval(cmd, b - 1);
            if (mdc !== em && !bad[0]) begin bad[0] = 1; fa[0] = {t[30:0], mdc}; fe[0] = {t[30:0], em}; end
            if (mdio_oe !== eo && !bad[3]) begin bad[3] = 1; fa[3] = {t[30:0], mdio_oe}; fe[3] = {t[30:0], eo}; end
            if (eo && mdio_o !== ev) begin
                if (c == se) begin
                    if (!bad[1]) begin bad[1] = 1; fa[1] = {t[30:0], mdio_o}; fe[1] = {t[30:0], ev}; end
                end else if (!bad[2]) begin
                    bad[2] = 1; fa[2] = {t[30:0], mdio_o}; fe[2] = {t[30:0], ev};
                end
            end
            if (c == 0) mdio_i = (b >= 48) ? phy[63-b] : 1'b1;
            if (poke) begin
                if (t == 3) begin
                    rd(2'd2, r);
                    chk(r == 32'h2, "R8 busy during frame", r, 32'h2);
                end
                if (t == 5) begin reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = ~cmd; end
                if (t == 6) begin reg_we = 1'b1; reg_addr = 2'd1; reg_wdata = spd_word(p_spd, p_hld); end
                if (t == 7) reg_we = 1'b0;
            end
            @(negedge clk);
        end
        chk(!bad[0], "R2 mdc shape {cycle,mdc}", fa[0], fe[0]);
        chk(!bad[1], "R3 bit at rising edge {cycle,mdio}", fa[1], fe[1]);
        chk(!bad[2], "R4 hold timing {cycle,mdio}", fa[2], fe[2]);
        chk(!bad[3], is_rd ? "R5 read release {cycle,oe}" : "R6 write drive {cycle,oe}", fa[3], fe[3]);
        chk(!mdc && !mdio_oe, "R10 idle pins {mdc,oe}", {30'd0, mdc, mdio_oe}, 32'd0);
        rd(2'd2, r);
        chk(r == 32'h1, "R7 flag set, busy clear", r, 32'h1);
        rd(2'd0, r);
        if (is_rd) chk(r == {cmd[31:16], phy}, "R5 read data", r, {cmd[31:16], phy});
        else       chk(r == cmd, poke ? "R8 ignored write" : "R6 data kept", r, cmd);
        wr(2'd2, 32'h0);
        rd(2'd2, r);
        chk(r == 32'h1, "R7 write 0 keeps flag", r, 32'h1);
        wr(2'd2, 32'h1);
        rd(2'd2, r);
        chk(r == 32'h0, "R7 write 1 clears flag", r, 32'h0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog all requirements actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] r;
        bit rdf;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(!mdc && !mdio_oe, "R1 pins after reset", {30'd0, mdc, mdio_oe}, 32'd0);
        rd(2'd0, r); chk(r == 0, "R1 data reg", r, 0);
        rd(2'd1, r); chk(r == 0, "R1 timing reg", r, 0);
        rd(2'd2, r); chk(r == 0, "R1 event reg", r, 0);
        // R9: only the timing fields are stored
        wr(2'd1, 32'hFFFF_FFFF);
        rd(2'd1, r); chk(r == 32'h0000_077E, "R9 timing mask", r, 32'h0000_077E);
        // Directed: slowest divider, largest hold, write frame
        run_frame(6'd63, 3'd7, 0, 0, 5'h1F, 5'h00, 16'hA5C3, 16'h0, 0, 6'd0, 3'd0);
        // Divider field 0 counts as 2, read frame
        run_frame(6'd0, 3'd0, 1, 1, 5'h01, 5'h1F, 16'h0, 16'hBEEF, 0, 6'd0, 3'd0);
        // Divider 1 with large hold: hold clamps to zero
        run_frame(6'd1, 3'd7, 1, 0, 5'h0A, 5'h15, 16'hFFFF, 16'h0, 0, 6'd0, 3'd0);
        // Ignored command and deferred timing change mid-frame (R8, R9)
        run_frame(6'd4, 3'd2, 1, 0, 5'h12, 5'h03, 16'h1234, 16'h0, 1, 6'd3, 3'd1);
        // R9: next frame runs with the timing written during the last one
        run_frame(6'd3, 3'd1, 0, 1, 5'h07, 5'h08, 16'h0, 16'h8001, 0, 6'd0, 3'd0);
        // Random frames
        for (int i = 0; i < 12; i++) begin
            rdf = $urandom_range(0, 1) == 1;
            run_frame(6'($urandom_range(0, 10)), 3'($urandom_range(0, 7)), 1, rdf,
                      5'($urandom), 5'($urandom), 16'($urandom), 16'($urandom), 0, 6'd0, 3'd0);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule